// File: doc/BRIEF.md
# Table Pointer and Byte Latch Unit

This block moves single bytes between program memory and data memory for table-read and table-write operations. It holds a 22-bit byte-address pointer and an 8-bit latch. Software loads the pointer through three byte-wide registers (low, high, upper) and loads the latch the same way. The instruction decoder issues a table request together with a two-bit stepping mode. The mode says whether the pointer stays put, is incremented or is decremented, and whether the step happens before or after the memory access.

The low 21 bits of the pointer address up to 2 MiB of program memory. Bit 21 selects the separate space that holds the device ID, the user ID and the configuration bits. Stepping only ever changes the low 21 bits: they wrap within that field, and bit 21 keeps its value. Toward memory the block drives a byte address, a read strobe and a write strobe. A read returns its byte one cycle after the strobe, and that byte is captured in the latch. A write presents the current latch byte together with a single-cycle write strobe.

Top module: `tblx_unit`

## Requirements
- R1: While reset is asserted and after it is released, all three pointer bytes, the latch, `done`, `mem_rd` and `mem_wr` are zero.
- R2: With `sw_wr_en` high, `sw_sel` code 0 writes `sw_wdata` into pointer bits 7:0, code 1 into bits 15:8 and code 2 into bits 21:16. `ptr_upper` reads bits 7:6 as zero, and writes to those bits have no effect.
- R3: With `sw_wr_en` high and `sw_sel` code 3, `sw_wdata` is loaded into the latch. The new value shows on `latch_byte` from the next cycle on.
- R4: Mode 0 (hold): the access uses the current pointer, and the pointer is unchanged afterwards.
- R5: Mode 1 (post-increment): the access uses the current pointer, and the pointer is then one higher.
- R6: Mode 2 (post-decrement): the access uses the current pointer, and the pointer is then one lower.
- R7: Mode 3 (pre-increment): the access uses pointer+1, and the pointer keeps that new value.
- R8: Increment and decrement act on bits 20:0 only and wrap within them. Bit 21 is never changed by stepping.
- R9: A read request (`req_valid` high, `req_write` low) raises `mem_rd` in the same cycle with the address on `mem_addr`. `done` is high in the next cycle, and from the cycle after that `latch_byte` holds the `mem_rdata` value of the cycle in which `done` was high.
- R10: A write request (`req_write` high) raises `mem_wr` for exactly that cycle, with the current latch byte on `mem_wdata`.
- R11: If a software pointer-byte write and a request fall in the same cycle, the written byte takes the software value, the step is discarded, and the other pointer bytes keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 low, 1 high, 2 upper, 3 latch |
| sw_wdata | input | 8 | Software write data |
| req_valid | input | 1 | Table request in this cycle |
| req_write | input | 1 | 1 for a table write, 0 for a table read |
| req_mode | input | 2 | Stepping mode: 0 hold, 1 post-inc, 2 post-dec, 3 pre-inc |
| ptr_low | output | 8 | Pointer bits 7:0 |
| ptr_high | output | 8 | Pointer bits 15:8 |
| ptr_upper | output | 8 | Pointer bits 21:16, with bits 7:6 zero |
| latch_byte | output | 8 | Latch contents |
| done | output | 1 | High in the cycle after a read strobe |
| mem_addr | output | 22 | Byte address of the access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data (latch byte) |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |

## Verification
The hardest conditions to reach are at the edges of the 21-bit field with bit 21 set or clear: a pre-increment from all ones, and a post-decrement from zero in either space. In those cases a carry or borrow must stop short of bit 21. The vector table loads each start pointer byte by byte through the software port, so these boundary values are set up directly and do not need millions of steps. The hardest timing case is a software byte write in the very cycle a request steps the pointer. A directed test drives both inputs on the same edge.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD     = 2'b00,
    STEP_POST_INC = 2'b01,
    STEP_POST_DEC = 2'b10,
    STEP_PRE_INC  = 2'b11
  } step_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'b00,
    SEL_HIGH  = 2'b01,
    SEL_UPPER = 2'b10,
    SEL_LATCH = 2'b11
  } sw_sel_e;
endpackage

// File: rtl/tblx_step.sv
module tblx_step
  import tblx_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int STEP_W = 21
) (
  input  logic [PTR_W-1:0] ptr_q,
  input  step_mode_e       mode,
  output logic [PTR_W-1:0] acc_addr,
  output logic [PTR_W-1:0] next_ptr
);
  localparam int TOP_W = PTR_W - STEP_W;
  localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};

  logic [STEP_W-1:0] low_inc;
  logic [STEP_W-1:0] low_dec;
  logic [TOP_W-1:0]  top_keep;

  assign top_keep = ptr_q[PTR_W-1:STEP_W];
  assign low_inc  = ptr_q[STEP_W-1:0] + ONE;
  assign low_dec  = ptr_q[STEP_W-1:0] - ONE;

  always_comb begin
    acc_addr = ptr_q;
    next_ptr = ptr_q;
    case (mode)
      STEP_POST_INC: next_ptr = {top_keep, low_inc};
      STEP_POST_DEC: next_ptr = {top_keep, low_dec};
      STEP_PRE_INC: begin
        acc_addr = {top_keep, low_inc};
        next_ptr = {top_keep, low_inc};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tblx_ptr_regs.sv
module tblx_ptr_regs
  import tblx_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int STEP_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_ptr_wr,
  input  sw_sel_e          sw_sel,
  input  logic [7:0]       sw_wdata,
  input  logic             step_en,
  input  logic [PTR_W-1:0] step_val,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int UP_W = PTR_W - 16;

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = sw_ptr_wr | step_en;

  always_comb begin
    ptr_d = ptr_q;
    if (sw_ptr_wr) begin
      case (sw_sel)
        SEL_LOW:   ptr_d[7:0]        = sw_wdata;
        SEL_HIGH:  ptr_d[15:8]       = sw_wdata;
        SEL_UPPER: ptr_d[PTR_W-1:16] = sw_wdata[UP_W-1:0];
        default: ;
      endcase
    end else if (step_en) begin
      ptr_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R8: stepping never moves the space-select bit
  a_r8_top_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sw_ptr_wr) |=> ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1]));

  // R11: a software write to the low byte wins over any step
  a_r11_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ptr_wr && sw_sel == SEL_LOW) |=> ptr_q[7:0] == $past(sw_wdata));
endmodule

// File: rtl/tblx_latch.sv
module tblx_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] latch_q,
  output logic              done
);
  logic              rd_pend_q;
  logic [DATA_W-1:0] latch_d;
  logic              latch_en;

  assign latch_en = sw_wr | rd_pend_q;
  assign latch_d  = sw_wr ? sw_wdata : mem_rdata;
  assign done     = rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= rd_issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  // R9: every read strobe is answered by done on the next cycle
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> done);

  // R9: the byte returned during done is what the latch holds next
  a_r9_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sw_wr) |=> latch_q == $past(mem_rdata));
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
  import tblx_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int STEP_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_sel,
  input  logic [7:0]        sw_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  output logic [7:0]        ptr_low,
  output logic [7:0]        ptr_high,
  output logic [7:0]        ptr_upper,
  output logic [DATA_W-1:0] latch_byte,
  output logic              done,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int UP_W = PTR_W - 16;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  sw_sel_e          sel;
  step_mode_e       mode;
  logic             sw_ptr_wr;
  logic             sw_lat_wr;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] acc_addr;
  logic [PTR_W-1:0] next_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign sel       = sw_sel_e'(sw_sel);
  assign mode      = step_mode_e'(req_mode);
  assign sw_ptr_wr = sw_wr_en && (sel != SEL_LATCH);
  assign sw_lat_wr = sw_wr_en && (sel == SEL_LATCH);

  tblx_step #(.PTR_W(PTR_W), .STEP_W(STEP_W)) u_step (
    .ptr_q    (ptr_q),
    .mode     (mode),
    .acc_addr (acc_addr),
    .next_ptr (next_ptr)
  );

  tblx_ptr_regs #(.PTR_W(PTR_W), .STEP_W(STEP_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sw_ptr_wr (sw_ptr_wr),
    .sw_sel    (sel),
    .sw_wdata  (sw_wdata),
    .step_en   (req_valid),
    .step_val  (next_ptr),
    .ptr_q     (ptr_q)
  );

  tblx_latch #(.DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .rd_issue  (mem_rd),
    .sw_wr     (sw_lat_wr),
    .sw_wdata  (sw_wdata[DATA_W-1:0]),
    .mem_rdata (mem_rdata),
    .latch_q   (latch_byte),
    .done      (done)
  );

  assign mem_addr  = acc_addr;
  assign mem_rd    = req_valid && !req_write;
  assign mem_wr    = req_valid && req_write;
  assign mem_wdata = latch_byte;

  assign ptr_low   = ptr_q[7:0];
  assign ptr_high  = ptr_q[15:8];
  assign ptr_upper = {{(8-UP_W){1'b0}}, ptr_q[PTR_W-1:16]};

  // R4: hold mode leaves the pointer untouched
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && mode == STEP_HOLD && !sw_ptr_wr) |=> $stable(ptr_q));

  // R5: post-increment raises the low field by one
  a_r5_post_inc: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && mode == STEP_POST_INC && !sw_ptr_wr)
      |=> ptr_q[STEP_W-1:0] == $past(ptr_q[STEP_W-1:0]) + 1'b1);

  // R7: the pre-increment access address becomes the new pointer
  a_r7_pre_inc_addr: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && mode == STEP_PRE_INC && !sw_ptr_wr) |=> ptr_q == $past(mem_addr));
endmodule

// File: tb/tb_tblx_unit.sv
module tb_tblx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en, req_valid, req_write;
  logic [1:0]  sw_sel, req_mode;
  logic [7:0]  sw_wdata;
  logic [7:0]  ptr_low, ptr_high, ptr_upper, latch_byte, mem_wdata;
  logic        done, mem_rd, mem_wr;
  logic [21:0] mem_addr;
  logic [7:0]  rdq = 8'h00;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tblx_unit dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .ptr_low(ptr_low), .ptr_high(ptr_high),
    .ptr_upper(ptr_upper), .latch_byte(latch_byte), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(rdq)
  );

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) rdq <= memf(mem_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] cur_ptr();
    return {ptr_upper[5:0], ptr_high, ptr_low};
  endfunction

  task automatic sw_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    sw_write(2'd0, p[7:0]);
    sw_write(2'd1, p[15:8]);
    sw_write(2'd2, {2'b00, p[21:16]});
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  mode;
    logic [21:0] start;
    logic [21:0] addr;
    logic [21:0] after;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 22'h012345, 22'h012345, 22'h012345},
    '{1'b0, 2'd1, 22'h0000FF, 22'h0000FF, 22'h000100},
    '{1'b0, 2'd2, 22'h010000, 22'h010000, 22'h00FFFF},
    '{1'b0, 2'd3, 22'h00ABCD, 22'h00ABCE, 22'h00ABCE},
    '{1'b0, 2'd1, 22'h1FFFFF, 22'h1FFFFF, 22'h000000},
    '{1'b0, 2'd3, 22'h3FFFFF, 22'h200000, 22'h200000},
    '{1'b1, 2'd2, 22'h200000, 22'h200000, 22'h3FFFFF},
    '{1'b1, 2'd0, 22'h155AA5, 22'h155AA5, 22'h155AA5},
    '{1'b1, 2'd3, 22'h000000, 22'h000001, 22'h000001},
    '{1'b0, 2'd2, 22'h000000, 22'h000000, 22'h1FFFFF}
  };

  function automatic string tag_for(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5 R8";
      2'd2: return "R6 R8";
      default: return "R7 R8";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_wr_en = 1'b0; sw_sel = 2'd0; sw_wdata = 8'h00;
    req_valid = 1'b0; req_write = 1'b0; req_mode = 2'd0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check({ptr_upper, ptr_high, ptr_low, latch_byte} == 32'h0, "R1 regs in reset",
          {ptr_upper, ptr_high, ptr_low, latch_byte}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({done, mem_rd, mem_wr} == 3'b000 && cur_ptr() == 22'h0 && latch_byte == 8'h0,
          "R1 after release", {cur_ptr(), latch_byte}, 32'h0);

    // R2: upper byte keeps only bits 5:0
    set_ptr(22'h000000);
    sw_write(2'd2, 8'hFF);
    check(ptr_upper == 8'h3F, "R2 upper bits 7:6", ptr_upper, 8'h3F);
    sw_write(2'd1, 8'hA7);
    sw_write(2'd0, 8'h19);
    check(cur_ptr() == 22'h3FA719, "R2 byte writes", cur_ptr(), 22'h3FA719);

    // R3: latch written by software
    sw_write(2'd3, 8'h96);
    check(latch_byte == 8'h96, "R3 latch write", latch_byte, 8'h96);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [7:0] wl;
      v = VECS[i];
      wl = 8'hC0 + 8'(i);
      set_ptr(v.start);
      if (v.wr) sw_write(2'd3, wl);
      @(negedge clk);
      req_valid = 1'b1; req_write = v.wr; req_mode = v.mode;
      #1;
      check(mem_addr == v.addr, {tag_for(v.mode), " access address"}, mem_addr, v.addr);
      if (v.wr)
        check(mem_wr && !mem_rd && mem_wdata == wl, "R10 write strobe/data",
              {mem_rd, mem_wr, mem_wdata}, {2'b01, wl});
      else
        check(mem_rd && !mem_wr, "R9 read strobe", {mem_rd, mem_wr}, 2'b10);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(cur_ptr() == v.after, {tag_for(v.mode), " pointer after"}, cur_ptr(), v.after);
      if (v.wr) begin
        check(!mem_wr, "R10 single-cycle strobe", mem_wr, 1'b0);
      end else begin
        check(done, "R9 done pulse", done, 1'b1);
        @(negedge clk);
        check(latch_byte == memf(v.addr) && !done, "R9 latch capture",
              {done, latch_byte}, {1'b0, memf(v.addr)});
      end
    end

    // R10: write right after a read presents the byte just read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_mode = 2'd0;
    #1;
    check(mem_wdata == memf(22'h000000), "R10 latch from read",
          mem_wdata, memf(22'h000000));
    @(negedge clk);
    req_valid = 1'b0;

    // R11: software write and step in the same cycle
    set_ptr(22'h050010);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mode = 2'd1;
    sw_wr_en = 1'b1; sw_sel = 2'd0; sw_wdata = 8'h80;
    @(negedge clk);
    req_valid = 1'b0; sw_wr_en = 1'b0;
    check(cur_ptr() == 22'h050080, "R11 software write wins", cur_ptr(), 22'h050080);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule